// File: doc/BRIEF.md
# MSK Transmit Bit Clock and Tone Modulator

This block turns a serial data stream into a phase-continuous two-tone sample stream for a downstream DAC. It runs from a 3.6864 MHz master clock. An external controller watches the bit clock this block drives and presents one data bit per period. The block takes each bit on a rising edge of that clock and plays the matching tone for exactly one bit period. Tones alternate without any phase jump.

Two control bits gate the function. The first one, `tx_sw2`, parks the bit clock high while it is 1 and lets it run while it is 0. The second one, `tx_sw1`, selects modem transmission. It is honoured only while `tx_sw2` is 0. Setting `tx_sw2` ends a burst gracefully: the bit already taken plays to its end, then the output falls silent. A rate input selects 2400 bps or 1200 bps, and each rate has its own tone pair.

Top module: `msk_tx_core`

## Requirements
- R1: While `tx_sw2` is 1 at a clock edge, `bit_clk` is 1 after that edge, and it shows no rising transition.
- R2: Once running, `bit_clk` toggles every 768 master cycles when `rate_slow`=0 (2400 bps) and every 1536 cycles when `rate_slow`=1 (1200 bps). A full period is therefore 1536 or 3072 cycles.
- R3: On the first edge that sees `tx_sw2`=0 after it was 1, `bit_clk` goes low. It first rises one half period later (768 or 1536 edges after that edge).
- R4: `tx_data` is taken on the edge where `bit_clk` rises, and only if `tx_sw1`=1 at that edge. The taken bit starts playing on the cycle after that edge.
- R5: Tone choice, with data 0 / data 1: 2400 Hz / 1200 Hz at `rate_slow`=0, and 1800 Hz / 1200 Hz at `rate_slow`=1. A 24-bit phase accumulator advances each busy cycle by round(f·2^24/3686400), which gives 10923, 5461 and 8192 for 2400, 1200 and 1800 Hz.
- R6: The phase accumulator is never cleared outside reset. It holds its value while idle, and the tone changes only when a new bit is taken. Consecutive busy samples therefore never jump by more than 4 LSB.
- R7: While busy, `sample` equals round(127·sin(2π(p+0.5)/256)), built from a 64-entry quarter-wave table. Here p is the top 8 accumulator bits, and the result is never 0. While idle, `sample` is 0.
- R8: After `tx_sw2` goes to 1, a bit in flight still plays for its full period (1536 or 3072 cycles from its start). `busy` then falls, and no further bit is taken.
- R9: With `tx_sw1`=0 the bit clock still runs, but `busy` stays 0 and `sample` stays 0.
- R10: During and right after reset, `bit_clk`=1, `busy`=0 and `sample`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 3.6864 MHz master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_slow | input | 1 | 0 = 2400 bps, 1 = 1200 bps |
| tx_sw2 | input | 1 | 1 parks the bit clock high and ends a burst |
| tx_sw1 | input | 1 | 1 selects modem transmission |
| tx_data | input | 1 | Serial data bit, taken at bit clock rise |
| bit_clk | output | 1 | Transmit bit clock toward the controller |
| sample | output | 8 | Signed tone sample for the DAC |
| busy | output | 1 | A bit is currently being played |

## Verification
The bench drives bursts at both rates, checks the first-rise delay, and checks each bit period against the rate. A design that counted the start from the wrong edge would shift the first rise by a cycle and fail the half-period check. A design that cut the drain short when `tx_sw2` rose would drop `busy` early and truncate the last tone. The bench also checks every busy-to-busy transition for a sample jump, which exposes an accumulator that is reset at a bit boundary. A run with `tx_sw1` low confirms the clock toggles while the output stays silent.

// File: rtl/msk_tx_pkg.sv
package msk_tx_pkg;

  // master cycles in one half of a bit period
  function automatic int unsigned half_bit_cycles(input int unsigned fclk_hz,
                                                  input int unsigned bps);
    return fclk_hz / (2 * bps);
  endfunction

  // rounded accumulator step for a tone of f_hz
  function automatic longint unsigned phase_step(input int unsigned f_hz,
                                                 input int unsigned fclk_hz,
                                                 input int unsigned phase_w);
    longint unsigned num;
    num = (64'(f_hz) << phase_w) + 64'(fclk_hz / 2);
    return num / 64'(fclk_hz);
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/msk_bitclk.sv
module msk_bitclk
  import msk_tx_pkg::*;
#(
  parameter int unsigned HALF_FAST = 768,
  parameter int unsigned HALF_SLOW = 1536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_slow,
  input  logic park,
  output logic bit_clk,
  output logic rise_evt
);
  localparam int unsigned HALF_MAX = max_u(HALF_FAST, HALF_SLOW);
  localparam int unsigned CNT_W    = $clog2(HALF_MAX);

  logic             run_q;
  logic             bclk_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;
  logic             half_done;

  assign last_cnt  = rate_slow ? CNT_W'(HALF_SLOW - 1) : CNT_W'(HALF_FAST - 1);
  assign half_done = run_q && (cnt_q >= last_cnt);
  // the edge at which the clock is about to go high
  assign rise_evt  = half_done && !bclk_q && !park;
  assign bit_clk   = bclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      bclk_q <= 1'b1;
      cnt_q  <= '0;
    end else if (park) begin
      run_q  <= 1'b0;
      bclk_q <= 1'b1;
      cnt_q  <= '0;
    end else if (!run_q) begin
      run_q  <= 1'b1;
      bclk_q <= 1'b0;
      cnt_q  <= '0;
    end else if (half_done) begin
      cnt_q  <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  a_r1_park_high: assert property (@(posedge clk) disable iff (!rst_n)
    park |=> bit_clk);

  a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!park && $past(park)) |=> !bit_clk);

  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(HALF_MAX - 1));

endmodule

// File: rtl/msk_modulator.sv
module msk_modulator
  import msk_tx_pkg::*;
#(
  parameter int unsigned FCLK_HZ    = 3686400,
  parameter int unsigned HALF_FAST  = 768,
  parameter int unsigned HALF_SLOW  = 1536,
  parameter int unsigned F0_FAST_HZ = 2400,
  parameter int unsigned F0_SLOW_HZ = 1800,
  parameter int unsigned F1_HZ      = 1200,
  parameter int unsigned PHASE_W    = 24,
  parameter int unsigned IDX_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             data_bit,
  input  logic             rate_slow,
  output logic             busy,
  output logic [IDX_W-1:0] phase_idx
);
  localparam int unsigned HALF_MAX = max_u(HALF_FAST, HALF_SLOW);
  localparam int unsigned LEFT_W   = $clog2(2 * HALF_MAX);
  localparam logic [PHASE_W-1:0] STEP_0F = PHASE_W'(phase_step(F0_FAST_HZ, FCLK_HZ, PHASE_W));
  localparam logic [PHASE_W-1:0] STEP_0S = PHASE_W'(phase_step(F0_SLOW_HZ, FCLK_HZ, PHASE_W));
  localparam logic [PHASE_W-1:0] STEP_1  = PHASE_W'(phase_step(F1_HZ, FCLK_HZ, PHASE_W));

  logic               busy_q;
  logic [LEFT_W-1:0]  left_q;
  logic [LEFT_W-1:0]  left_init;
  logic [PHASE_W-1:0] inc_q;
  logic [PHASE_W-1:0] inc_sel;
  logic [PHASE_W-1:0] phase_q;

  always_comb begin
    unique case ({rate_slow, data_bit})
      2'b00:   inc_sel = STEP_0F;
      2'b10:   inc_sel = STEP_0S;
      default: inc_sel = STEP_1;
    endcase
  end

  assign left_init = rate_slow ? LEFT_W'(2 * HALF_SLOW - 1) : LEFT_W'(2 * HALF_FAST - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      left_q  <= '0;
      inc_q   <= '0;
      phase_q <= '0;
    end else begin
      if (busy_q) phase_q <= phase_q + inc_q;
      if (load) begin
        busy_q <= 1'b1;
        left_q <= left_init;
        inc_q  <= inc_sel;
      end else if (busy_q) begin
        if (left_q == '0) busy_q <= 1'b0;
        else              left_q <= left_q - 1'b1;
      end
    end
  end

  assign busy      = busy_q;
  assign phase_idx = phase_q[PHASE_W-1 -: IDX_W];

  a_r6_step_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(inc_q) |-> $past(load));

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> $stable(phase_q));

  a_r8_no_drop_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> !$past(load));

endmodule

// File: rtl/msk_sine_lut.sv
module msk_sine_lut #(
  parameter int unsigned LUT_ADDR_W = 6,
  parameter int unsigned SAMPLE_W   = 8
) (
  input  logic                       en,
  input  logic [LUT_ADDR_W+1:0]      idx,
  output logic signed [SAMPLE_W-1:0] sample
);
  localparam int unsigned QN  = 2 ** LUT_ADDR_W;
  localparam int unsigned AMP = 2 ** (SAMPLE_W - 1) - 1;
  localparam real         HALF_PI = 1.5707963267948966;

  logic [SAMPLE_W-1:0]   quarter [QN];
  logic [LUT_ADDR_W-1:0] addr;
  logic [SAMPLE_W-1:0]   mag;

  for (genvar k = 0; k < QN; k++) begin : g_quarter
    localparam real ANG = HALF_PI * (real'(k) + 0.5) / real'(QN);
    localparam int  VAL = $rtoi(real'(AMP) * $sin(ANG) + 0.5);
    assign quarter[k] = SAMPLE_W'(VAL);
  end

  // second and fourth quadrants read the table backwards
  assign addr = idx[LUT_ADDR_W] ? ~idx[LUT_ADDR_W-1:0] : idx[LUT_ADDR_W-1:0];
  assign mag  = quarter[addr];

  always_comb begin
    if (!en)                     sample = '0;
    else if (idx[LUT_ADDR_W+1])  sample = $signed(~mag + 1'b1);
    else                         sample = $signed(mag);
  end

endmodule

// File: rtl/msk_tx_core.sv
module msk_tx_core
  import msk_tx_pkg::*;
#(
  parameter int unsigned FCLK_HZ    = 3686400,
  parameter int unsigned FAST_BPS   = 2400,
  parameter int unsigned SLOW_BPS   = 1200,
  parameter int unsigned F0_FAST_HZ = 2400,
  parameter int unsigned F0_SLOW_HZ = 1800,
  parameter int unsigned F1_HZ      = 1200,
  parameter int unsigned PHASE_W    = 24,
  parameter int unsigned LUT_ADDR_W = 6,
  parameter int unsigned SAMPLE_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rate_slow,
  input  logic                       tx_sw2,
  input  logic                       tx_sw1,
  input  logic                       tx_data,
  output logic                       bit_clk,
  output logic signed [SAMPLE_W-1:0] sample,
  output logic                       busy
);
  localparam int unsigned HALF_FAST = half_bit_cycles(FCLK_HZ, FAST_BPS);
  localparam int unsigned HALF_SLOW = half_bit_cycles(FCLK_HZ, SLOW_BPS);
  localparam int unsigned IDX_W     = LUT_ADDR_W + 2;

  logic             rise_evt;
  logic             modem_sel;
  logic             load;
  logic [IDX_W-1:0] phase_idx;

  assign modem_sel = tx_sw1 && !tx_sw2;
  assign load      = rise_evt && modem_sel;

  msk_bitclk #(
    .HALF_FAST(HALF_FAST),
    .HALF_SLOW(HALF_SLOW)
  ) u_bitclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate_slow(rate_slow),
    .park     (tx_sw2),
    .bit_clk  (bit_clk),
    .rise_evt (rise_evt)
  );

  msk_modulator #(
    .FCLK_HZ   (FCLK_HZ),
    .HALF_FAST (HALF_FAST),
    .HALF_SLOW (HALF_SLOW),
    .F0_FAST_HZ(F0_FAST_HZ),
    .F0_SLOW_HZ(F0_SLOW_HZ),
    .F1_HZ     (F1_HZ),
    .PHASE_W   (PHASE_W),
    .IDX_W     (IDX_W)
  ) u_mod (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .data_bit (tx_data),
    .rate_slow(rate_slow),
    .busy     (busy),
    .phase_idx(phase_idx)
  );

  msk_sine_lut #(
    .LUT_ADDR_W(LUT_ADDR_W),
    .SAMPLE_W  (SAMPLE_W)
  ) u_lut (
    .en    (busy),
    .idx   (phase_idx),
    .sample(sample)
  );

  a_r4_take_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bit_clk) && $past(modem_sel)) |-> busy);

  a_r9_start_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(tx_sw1) && $rose(bit_clk)));

  a_r7_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sample == '0));

  a_r7_sign_follows_phase: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((sample != '0) && (sample[SAMPLE_W-1] == phase_idx[IDX_W-1])));

endmodule

// File: tb/sim_msk_tx_core.sv
`timescale 1ns/1ps
module sim_msk_tx_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rate_slow = 1'b0;
  logic tx_sw2 = 1'b1;
  logic tx_sw1 = 1'b0;
  logic tx_data = 1'b0;
  logic bit_clk;
  logic signed [7:0] sample;
  logic busy;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  msk_tx_core u0 (
    .clk(clk), .rst_n(rst_n), .rate_slow(rate_slow), .tx_sw2(tx_sw2),
    .tx_sw1(tx_sw1), .tx_data(tx_data), .bit_clk(bit_clk),
    .sample(sample), .busy(busy)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sine_ref(input int p);
    real v;
    v = 127.0 * $sin(2.0 * 3.14159265358979 * (real'(p) + 0.5) / 256.0);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction

  function automatic int tone_step(input bit rate, input bit d);
    real f;
    f = d ? 1200.0 : (rate ? 1800.0 : 2400.0);
    return $rtoi(f * 16777216.0 / 3686400.0 + 0.5);
  endfunction

  // behavioural reference, advanced on every rising edge
  int m_run, m_bclk, m_cnt, m_busy, m_left, m_inc;
  int unsigned m_phase;
  always @(posedge clk) begin
    int h;
    bit rise;
    h = rate_slow ? 1536 : 768;
    rise = 1'b0;
    if (!rst_n) begin
      m_run = 0; m_bclk = 1; m_cnt = 0; m_busy = 0; m_left = 0; m_inc = 0; m_phase = 0;
    end else begin
      if (tx_sw2) begin m_run = 0; m_bclk = 1; m_cnt = 0; end
      else if (m_run == 0) begin m_run = 1; m_bclk = 0; m_cnt = 0; end
      else if (m_cnt == h - 1) begin
        m_cnt = 0; m_bclk = 1 - m_bclk; rise = (m_bclk == 1);
      end else m_cnt++;
      if (m_busy != 0) m_phase = (m_phase + m_inc) & 32'h00FF_FFFF;
      if (rise && tx_sw1) begin
        m_busy = 1; m_left = 2 * h - 1; m_inc = tone_step(rate_slow, tx_data);
      end else if (m_busy != 0) begin
        if (m_left == 0) m_busy = 0; else m_left--;
      end
    end
  end

  // per-cycle comparison away from the active edge
  int prev_s = 0;
  int prev_b = 0;
  always @(negedge clk) begin
    int exp_s;
    cycles++;
    if (rst_n && !done) begin
      exp_s = (m_busy != 0) ? sine_ref(int'(m_phase >> 16)) : 0;
      check(tx_sw2 ? "R1 bit_clk parked" : "R2 bit_clk timing", int'(bit_clk), m_bclk);
      check("R8 busy", int'(busy), m_busy);
      check("R7 sample (tone R5, data R4)", int'(sample), exp_s);
      if (busy && prev_b != 0) begin
        int d;
        d = int'(sample) - prev_s;
        if (d < 0) d = -d;
        check("R6 continuity jump<=4", (d <= 4) ? 1 : 0, 1);
      end
      prev_s = int'(sample);
      prev_b = int'(busy);
    end
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 190000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic burst(input bit rate, input bit sel, input int nbits, input logic [31:0] pat);
    int h, n;
    h = rate ? 1536 : 768;
    @(negedge clk);
    rate_slow = rate; tx_sw1 = sel; tx_data = pat[0]; tx_sw2 = 1'b0;
    n = 0;
    forever begin @(negedge clk); n++; if (bit_clk) break; end
    check("R3 first rise delay", n, h + 1);
    check(sel ? "R4 bit taken" : "R9 no bit taken", int'(busy), sel ? 1 : 0);
    for (int i = 1; i < nbits; i++) begin
      bit seen_low;
      tx_data = pat[i];
      n = 0; seen_low = 1'b0;
      forever begin
        @(negedge clk); n++;
        if (!bit_clk) seen_low = 1'b1;
        else if (seen_low) break;
      end
      check("R2 bit period", n, 2 * h);
      check(sel ? "R4 bit taken" : "R9 no bit taken", int'(busy), sel ? 1 : 0);
    end
    tx_sw2 = 1'b1;
    n = 0;
    while (busy) begin
      @(negedge clk); n++;
      check("R1 parked during drain", int'(bit_clk), 1);
      if (n > 4 * h) break;
    end
    check(sel ? "R8 drain length" : "R9 silent drain", n, sel ? 2 * h : 0);
    repeat (50) @(negedge clk);
    check("R8 stays idle", int'(busy), 0);
    check("R7 idle sample", int'(sample), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R10 reset bit_clk", int'(bit_clk), 1);
    check("R10 reset busy", int'(busy), 0);
    check("R10 reset sample", int'(sample), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after reset bit_clk", int'(bit_clk), 1);
    check("R10 after reset busy", int'(busy), 0);
    burst(1'b0, 1'b1, 12, 32'h0000_A5C3);
    burst(1'b0, 1'b0, 3, 32'h0000_0005);
    burst(1'b1, 1'b1, 8, 32'h0000_006B);
    burst(1'b0, 1'b1, 4, 32'h0000_00F0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule